// File: doc/BRIEF.md
# Two-Channel UART Register Access Front End

This block sits between a CPU bus and the two register sets of a dual-channel UART. It turns a 3-bit register address, a channel select and read/write strobes into per-channel register enables. It also steers read data back from whichever channel is selected. Each channel carries a small generic register set. Its line-control register at address 3 holds that channel's divisor-access bit in bit 7. When that bit is 1, addresses 0 and 1 open the channel's two divisor latches instead of the normal registers.

A single shared mode register is reached at address 2 while the addressed channel's divisor-access bit is set. Its bit 0 is the broadcast control. While it is 1, every CPU write lands on the same address in both channels at the same time, so both channels can be set up with one pass of writes. Reads keep following the channel select. Each channel decodes a broadcast write with its own divisor-access bit. When the two bits disagree on a broadcast write to addresses 0 to 2, the `dlab_mismatch` output flags it.

Top module: `uart2_regfront`

## Requirements
- R1: After reset, every channel register, both divisor latches of each channel and the shared mode register read as 0x00, and broadcast is off.
- R2: With the addressed channel's divisor-access bit (bit 7 of address 3) at 1, address 2 reads and writes the shared mode register. Only bit 0 is stored, and bits 7:1 read as 0.
- R3: The shared mode register can be written through either channel, and it reads back the same value through both channels.
- R4: With broadcast off (mode bit 0 = 0), a write changes only the register of the channel chosen by `ch_sel` (0 = channel 0, 1 = channel 1).
- R5: With broadcast on, a write stores `wdata` at the addressed register of both channels in the same cycle.
- R6: Read data always comes from the channel chosen by `ch_sel`, whether broadcast is on or off.
- R7: With a channel's divisor-access bit at 1, address 0 and address 1 reach that channel's low and high divisor latches. These latches are kept apart from the normal registers at the same addresses.
- R8: During a broadcast write to address 0, 1 or 2, each channel decodes the write with its own divisor-access bit. `dlab_mismatch` is 1 in that cycle exactly when the two bits differ.
- R9: `rdata` is 0x00 whenever `rd_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 3 | Register address |
| ch_sel | input | 1 | Channel select (0 or 1) |
| wr_en | input | 1 | Write strobe, committed at the rising edge |
| rd_en | input | 1 | Read strobe, gates `rdata` |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from the selected channel |
| bcast_on | output | 1 | Current broadcast control bit |
| dlab_mismatch | output | 1 | Broadcast write to address 0 to 2 while the two channels' divisor-access bits differ |

## Verification
Writes are tried with broadcast off and with it on. Each one is read back through both channels, which shows a write that leaked to the other channel apart from one that did not spread. The same addresses are tried with the divisor-access bit clear and set, which shows the divisor latches and the mode register apart from the normal registers that share their addresses. A directed sequence sets the two channels to different divisor-access values and then broadcasts to addresses 1 and 2, to check the per-channel decode and the mismatch flag. A long random mix of writes and reads with a fixed seed follows. It is compared against a bench model of the register sets.

// File: rtl/uart2_rf_pkg.sv
// Package: shared widths and register addresses of the two-channel register front end.
// Assumes exactly two channels; address roles follow the channel register layout.
package uart2_rf_pkg;
    localparam int DW        = 8;
    localparam int AW        = 3;
    localparam int NCH       = 2;
    localparam int NREG      = 1 << AW;
    localparam int LCR_ADDR  = 3;
    localparam int DLAB_BIT  = 7;
    localparam int DLL_ADDR  = 0;
    localparam int DLM_ADDR  = 1;
    localparam int MODE_ADDR = 2;

    typedef logic [DW-1:0] byte_t;
    typedef logic [AW-1:0] addr_t;
endpackage

// File: rtl/uart2_wr_decode.sv
// Write decoder: builds per-channel write enables from strobe, select and broadcast.
// Assumes each channel supplies its own divisor-access bit; decoding uses it per channel.
module uart2_wr_decode
    import uart2_rf_pkg::*;
(
    input  logic           wr_en,
    input  logic           ch_sel,
    input  addr_t          addr,
    input  logic           bcast,
    input  logic [NCH-1:0] dlab,
    output logic [NCH-1:0] wr_reg,
    output logic [NCH-1:0] wr_dll,
    output logic [NCH-1:0] wr_dlm,
    output logic           wr_mode,
    output logic           mismatch
);
    logic [NCH-1:0] hit;
    logic [NCH-1:0] mode_hit;
    localparam int LOW_SPAN = MODE_ADDR + 1;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        // channel hit: selected channel, or every channel during broadcast
        always_comb begin
            hit[c]      = wr_en && (bcast || (ch_sel == c[0]));
            wr_dll[c]   = hit[c] && dlab[c] && (addr == addr_t'(DLL_ADDR));
            wr_dlm[c]   = hit[c] && dlab[c] && (addr == addr_t'(DLM_ADDR));
            mode_hit[c] = hit[c] && dlab[c] && (addr == addr_t'(MODE_ADDR));
            wr_reg[c]   = hit[c] && !wr_dll[c] && !wr_dlm[c] && !mode_hit[c];
        end
    end

    // shared mode register written when any hit channel decodes it
    always_comb wr_mode = |mode_hit;

    // flag a broadcast write in the low window while decode bits disagree
    always_comb mismatch = wr_en && bcast && (int'(addr) < LOW_SPAN) && (dlab[0] != dlab[1]);
endmodule

// File: rtl/uart2_chan_regs.sv
// Generic channel register set: normal registers plus two divisor latches.
// Assumes the mode register at address 2 lives outside; reads it as 0 here.
module uart2_chan_regs
    import uart2_rf_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_reg,
    input  logic  wr_dll,
    input  logic  wr_dlm,
    input  addr_t addr,
    input  byte_t wdata,
    output byte_t rd_val,
    output logic  dlab,
    output byte_t lcr
);
    byte_t regs [NREG];
    byte_t dll_q;
    byte_t dlm_q;

    // normal register storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (wr_reg) begin
            regs[addr] <= wdata;
        end
    end

    // divisor latch storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dll_q <= '0;
            dlm_q <= '0;
        end else begin
            if (wr_dll) dll_q <= wdata;
            if (wr_dlm) dlm_q <= wdata;
        end
    end

    assign lcr  = regs[LCR_ADDR];
    assign dlab = lcr[DLAB_BIT];

    // read selection by address and own divisor-access bit
    always_comb begin
        rd_val = regs[addr];
        if (dlab) begin
            if (addr == addr_t'(DLL_ADDR))       rd_val = dll_q;
            else if (addr == addr_t'(DLM_ADDR))  rd_val = dlm_q;
            else if (addr == addr_t'(MODE_ADDR)) rd_val = '0;
        end
    end

    // R7: divisor latch write leaves the normal register at that address untouched
    assert_dll_apart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dll |=> $stable(regs[DLL_ADDR]));
endmodule

// File: rtl/uart2_mode_reg.sv
// Shared mode register: holds the broadcast control bit, upper bits read zero.
// Assumes the decoder raises wr_en only for a divisor-access address-2 write.
module uart2_mode_reg
    import uart2_rf_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  byte_t wdata,
    output byte_t rd_val,
    output logic  bcast
);
    logic bit0_q;

    // broadcast control bit storage
    always_ff @(posedge clk) begin
        if (!rst_n)     bit0_q <= 1'b0;
        else if (wr_en) bit0_q <= wdata[0];
    end

    assign bcast  = bit0_q;
    assign rd_val = {{(DW-1){1'b0}}, bit0_q};
endmodule

// File: rtl/uart2_regfront.sv
// Top: register access front end of a two-channel UART with write broadcast.
// Assumes combinational read data and writes committed at the rising clock edge.
module uart2_regfront
    import uart2_rf_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          ch_sel,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          bcast_on,
    output logic          dlab_mismatch
);
    logic [NCH-1:0] dlab;
    logic [NCH-1:0] wr_reg;
    logic [NCH-1:0] wr_dll;
    logic [NCH-1:0] wr_dlm;
    logic           wr_mode;
    byte_t          ch_rd  [NCH];
    byte_t          ch_lcr [NCH];
    byte_t          mode_rd;

    uart2_wr_decode u_dec (
        .wr_en    (wr_en),
        .ch_sel   (ch_sel),
        .addr     (addr),
        .bcast    (bcast_on),
        .dlab     (dlab),
        .wr_reg   (wr_reg),
        .wr_dll   (wr_dll),
        .wr_dlm   (wr_dlm),
        .wr_mode  (wr_mode),
        .mismatch (dlab_mismatch)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        uart2_chan_regs u_regs (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_reg (wr_reg[c]),
            .wr_dll (wr_dll[c]),
            .wr_dlm (wr_dlm[c]),
            .addr   (addr),
            .wdata  (wdata),
            .rd_val (ch_rd[c]),
            .dlab   (dlab[c]),
            .lcr    (ch_lcr[c])
        );
    end

    uart2_mode_reg u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_mode),
        .wdata  (wdata),
        .rd_val (mode_rd),
        .bcast  (bcast_on)
    );

    // read mux: selected channel, mode register when that channel decodes it
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (dlab[ch_sel] && addr == addr_t'(MODE_ADDR)) rdata = mode_rd;
            else                                          rdata = ch_rd[ch_sel];
        end
    end

    // R1: broadcast is off in the cycle after reset
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> !bcast_on);

    // R5: broadcast line-control write reaches both channels
    assert_bcast_both_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bcast_on && addr == addr_t'(LCR_ADDR))
        |=> (ch_lcr[0] == $past(wdata)) && (ch_lcr[1] == $past(wdata)));

    // R4: without broadcast the other channel's line control holds
    assert_single_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !bcast_on && !ch_sel) |=> $stable(ch_lcr[1]));

    // R2: mode register readback carries zeros above bit 0
    assert_mode_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && dlab[ch_sel] && addr == addr_t'(MODE_ADDR)) |-> (rdata[DW-1:1] == '0));

    // R6: line-control reads come from the selected channel
    assert_read_steer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == addr_t'(LCR_ADDR)) |-> (rdata == ch_lcr[ch_sel]));

    // R9: idle read strobe gives zero data
    assert_rd_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rdata == '0));
endmodule

// File: tb/uart2_regfront_tb.sv
// Bench: directed corners then fixed-seed random mix, checked against a bench model.
module uart2_regfront_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       ch_sel = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       bcast_on;
    logic       dlab_mismatch;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [7:0] m_reg [2][8];
    logic [7:0] m_dll [2];
    logic [7:0] m_dlm [2];
    logic       m_mode;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart2_regfront u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ch_sel(ch_sel),
        .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
        .bcast_on(bcast_on), .dlab_mismatch(dlab_mismatch)
    );

    function automatic logic [7:0] exp_read(input logic ch, input logic [2:0] a);
        logic dl = m_reg[ch][3][7];
        if (dl && a == 3'd0) return m_dll[ch];
        if (dl && a == 3'd1) return m_dlm[ch];
        if (dl && a == 3'd2) return {7'b0, m_mode};
        return m_reg[ch][a];
    endfunction

    function automatic logic exp_mismatch(input logic [2:0] a);
        return m_mode && (a < 3'd3) && (m_reg[0][3][7] != m_reg[1][3][7]);
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic model_write(input logic ch, input logic [2:0] a, input logic [7:0] d);
        logic dl [2];
        logic mode_hit = 1'b0;
        dl[0] = m_reg[0][3][7];
        dl[1] = m_reg[1][3][7];
        for (int c = 0; c < 2; c++) begin
            if (m_mode || ch == c[0]) begin
                if (dl[c] && a == 3'd0)      m_dll[c] = d;
                else if (dl[c] && a == 3'd1) m_dlm[c] = d;
                else if (dl[c] && a == 3'd2) mode_hit = 1'b1;
                else                         m_reg[c][a] = d;
            end
        end
        if (mode_hit) m_mode = d[0];
    endtask

    task automatic do_write(input logic ch, input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        ch_sel = ch; addr = a; wdata = d; wr_en = 1'b1; rd_en = 1'b0;
        #1;
        check("R8 mismatch flag", {7'b0, dlab_mismatch}, {7'b0, exp_mismatch(a)});
        model_write(ch, a, d);
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic do_read(input string req, input logic ch, input logic [2:0] a);
        @(negedge clk);
        ch_sel = ch; addr = a; rd_en = 1'b1; wr_en = 1'b0;
        #1;
        check(req, rdata, exp_read(ch, a));
        rd_en = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        int unsigned seed = 32'h1234_5678;
        void'($urandom(seed));
        for (int c = 0; c < 2; c++) begin
            for (int a = 0; a < 8; a++) m_reg[c][a] = '0;
            m_dll[c] = '0; m_dlm[c] = '0;
        end
        m_mode = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state of both channels and broadcast bit
        for (int a = 0; a < 8; a++) begin
            do_read("R1 reset ch0", 1'b0, a[2:0]);
            do_read("R1 reset ch1", 1'b1, a[2:0]);
        end
        check("R1 bcast off", {7'b0, bcast_on}, 8'h00);

        // R4: single-channel write stays in channel 0
        do_write(1'b0, 3'd4, 8'h5A);
        do_read("R4 own channel", 1'b0, 3'd4);
        do_read("R4 other channel", 1'b1, 3'd4);

        // R2/R3: mode register via channel 1, read via both
        do_write(1'b1, 3'd3, 8'h80);
        do_write(1'b1, 3'd2, 8'hFF);
        do_read("R2 mode readback", 1'b1, 3'd2);
        do_write(1'b0, 3'd3, 8'h80);
        do_read("R3 mode via ch0", 1'b0, 3'd2);
        check("R3 bcast on", {7'b0, bcast_on}, 8'h01);

        // R5/R7: broadcast divisor latch write, then normal register
        do_write(1'b0, 3'd0, 8'h11);
        do_read("R7 dll ch1", 1'b1, 3'd0);
        do_write(1'b1, 3'd3, 8'h03);
        do_read("R7 normal reg0 apart", 1'b0, 3'd0);
        do_write(1'b0, 3'd0, 8'h22);
        do_read("R5 bcast ch0", 1'b0, 3'd0);
        do_read("R5 bcast ch1", 1'b1, 3'd0);

        // R6: reads follow select while broadcast is on
        do_read("R6 read ch0", 1'b0, 3'd4);
        do_read("R6 read ch1", 1'b1, 3'd4);

        // R8: mismatched divisor-access bits under broadcast
        do_write(1'b0, 3'd3, 8'h80);
        do_write(1'b0, 3'd2, 8'h00);
        do_write(1'b1, 3'd3, 8'h00);
        do_write(1'b0, 3'd2, 8'h01);
        do_write(1'b1, 3'd1, 8'h77);
        do_read("R8 ch0 dlm", 1'b0, 3'd1);
        do_read("R8 ch1 reg1", 1'b1, 3'd1);
        do_write(1'b1, 3'd2, 8'h00);
        do_read("R8 ch1 reg2", 1'b1, 3'd2);
        do_read("R8 mode cleared", 1'b0, 3'd2);

        // R9: idle read strobe
        @(negedge clk);
        rd_en = 1'b0; ch_sel = 1'b0; addr = 3'd4;
        #1 check("R9 idle rdata", rdata, 8'h00);

        // random mix of writes and reads, all requirements against model
        for (int i = 0; i < 600; i++) begin
            logic       ch = 1'($urandom);
            logic [2:0] a  = 3'($urandom);
            logic [7:0] d  = 8'($urandom);
            if ($urandom % 2) do_write(ch, a, d);
            else              do_read("R6 random read", ch, a);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule